// File: doc/BRIEF.md
# Multi-Mode Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. It divides the system clock down to a conversion tick and presents trial codes to an external ladder DAC. It reads back one comparator bit for each trial and resolves the code one bit at a time, from the most significant bit to the least. It steps through up to six analog channels in one of five modes and stores each finished code in that channel's own result register. A done strobe marks each stored result.

Software drives the block through a small write/read register port. A write that sets the start bit begins a run, but only when the reference-connect bit in the same write is 1. Single runs clear the start bit themselves when they finish. Looping runs continue until software writes the start bit back to 0. The run then ends once the channel in progress has finished.

Top module: `adc_sar_sequencer`

## Requirements
- R1: Reset state: busy and done are 0, dacCode is 0, and the control, channel and result registers all read 0.
- R2: Register map. The control register is at address 0: mode in bits [2:0], start in bit 3, refOn in bit 4, sample-and-hold enable in bit 5, prescale code in bits [7:6]. The channel field is at address 1, bits [2:0]. A value above 5 written there is stored as 5. Channel k's result reads at address 2+k.
- R3: Each channel resolves by successive approximation. cmpHigh=1 means the analog input is at or above dacCode. The stored result is the largest code that the input reaches.
- R4: Prescale codes 0, 1 and 2 give a conversion tick every 1, 2 and 4 clocks. Code 3 acts as 4.
- R5: One channel takes 49 ticks with sample-and-hold off and 28 ticks with it on. The trial codes use the last 8 ticks. A one-shot done comes 2 + len*div clocks after the clock on which the start write is driven, and repeat results are spaced len*div clocks apart.
- R6: A start write with bit 4 = 0 is ignored. The start bit reads 0 on the next cycle, and no conversion and no done follow.
- R7: Mode 0 (one-shot) converts the channel field once, clears the start bit and goes idle.
- R8: Mode 1 (repeat) converts the channel field again and again. When software clears start, exactly one more result follows and then busy drops.
- R9: Mode 2 (single sweep) converts AN0 up to the channel field once, in ascending order, then clears start.
- R10: Mode 3 (loop sweep) cycles AN0 up to the channel field until start is cleared, and then finishes the current channel.
- R11: Mode 4 (loop sweep with AN0 interleaved) runs 0,1,0,2,...,0,last and repeats, stopping in the same way as R10.
- R12: done is high for exactly one clock after each result write. It is seen only while a run is active.
- R13: dacCode is 0 whenever the block is idle. chanSel stays within 0..5 and holds steady for the whole of a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data, combinational from rdAddr |
| cmpHigh | input | 1 | Comparator: analog input is at or above dacCode |
| dacCode | output | 8 | Trial code for the ladder DAC |
| chanSel | output | 3 | Analog channel being converted |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-clock pulse after a result write |

## Verification
The assertions assume that cmpHigh settles within the same clock as the trial code it is judging. The bench keeps to this by deriving cmpHigh combinationally from a stored per-channel input value. The reference-gating property also assumes that software does not clear refOn in the clock just after a start write. The bench keeps control writes away from a run's first cycles and changes only the start bit while a run is active.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W  = 8;
  localparam int CH_W   = 3;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    MODE_ONCE     = 3'd0,
    MODE_REPEAT   = 3'd1,
    MODE_SWEEP    = 3'd2,
    MODE_LOOP     = 3'd3,
    MODE_LOOP_AN0 = 3'd4
  } mode_e;

  typedef struct packed {
    logic            tick;
    logic            sarActive;
    logic [2:0]      bitIdx;
    logic            clearApprox;
    logic            writeResult;
    logic            clearStart;
    logic [CH_W-1:0] chan;
  } strobe_t;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic [1:0] divSel,
  output logic       tick
);
  logic [1:0] preCnt;
  logic [1:0] divM1;

  always_comb begin
    case (divSel)
      2'd0:    divM1 = 2'd0;
      2'd1:    divM1 = 2'd1;
      default: divM1 = 2'd3;
    endcase
  end

  assign tick = run && (preCnt == divM1);

  always_ff @(posedge clk) begin
    if (!rstN || !run) preCnt <= '0;
    else if (tick)     preCnt <= '0;
    else               preCnt <= preCnt + 2'd1;
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int LEN_PLAIN = 49,
  parameter int LEN_SH    = 28
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            startFlag,
  input  logic [2:0]      mode,
  input  logic [CH_W-1:0] chanField,
  input  logic            shEn,
  output logic            busy,
  output logic            done,
  output strobe_t         stb
);
  localparam int CNT_W = $clog2(LEN_PLAIN);

  logic            busyQ, doneQ;
  logic [CNT_W-1:0] tickCnt, lenM1;
  logic [CH_W-1:0] chanQ, targetQ, nextChan, nextTarget, firstChan;
  logic            sarPhase, endTick, keepGoing;

  assign lenM1    = shEn ? CNT_W'(LEN_SH - 1) : CNT_W'(LEN_PLAIN - 1);
  assign sarPhase = busyQ && (tickCnt >= lenM1 - CNT_W'(RES_W - 1));
  assign endTick  = busyQ && tick && (tickCnt == lenM1);

  always_comb begin
    keepGoing  = 1'b0;
    nextChan   = chanQ;
    nextTarget = targetQ;
    case (mode)
      MODE_REPEAT: keepGoing = startFlag;
      MODE_SWEEP: begin
        keepGoing = startFlag && (chanQ < chanField);
        nextChan  = chanQ + 1'b1;
      end
      MODE_LOOP: begin
        keepGoing = startFlag;
        nextChan  = (chanQ >= chanField) ? '0 : chanQ + 1'b1;
      end
      MODE_LOOP_AN0: begin
        keepGoing = startFlag;
        if (chanQ == '0) begin
          nextChan = (chanField == '0) ? '0 : targetQ;
        end else begin
          nextChan   = '0;
          nextTarget = (chanQ >= chanField) ? CH_W'(1) : chanQ + 1'b1;
        end
      end
      default: keepGoing = 1'b0;
    endcase
  end

  assign firstChan = (mode == MODE_SWEEP || mode == MODE_LOOP || mode == MODE_LOOP_AN0)
                     ? '0 : chanField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      tickCnt <= '0;
      chanQ   <= '0;
      targetQ <= CH_W'(1);
    end else begin
      doneQ <= endTick;
      if (!busyQ) begin
        if (startFlag) begin
          busyQ   <= 1'b1;
          tickCnt <= '0;
          chanQ   <= firstChan;
          targetQ <= CH_W'(1);
        end
      end else if (tick) begin
        if (endTick) begin
          tickCnt <= '0;
          if (keepGoing) begin
            chanQ   <= nextChan;
            targetQ <= nextTarget;
          end else begin
            busyQ <= 1'b0;
          end
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  always_comb begin
    stb.tick        = tick;
    stb.sarActive   = sarPhase;
    stb.bitIdx      = 3'(lenM1 - tickCnt);
    stb.clearApprox = !busyQ || endTick;
    stb.writeResult = endTick;
    stb.clearStart  = endTick && !keepGoing;
    stb.chan        = chanQ;
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_seq_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [RES_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              cmpHigh,
  input  strobe_t           stb,
  output logic [RES_W-1:0]  rdData,
  output logic [RES_W-1:0]  dacCode,
  output logic              startFlag,
  output logic [2:0]        mode,
  output logic [CH_W-1:0]   chanField,
  output logic              shEn,
  output logic [1:0]        divSel,
  output logic              refOn
);
  logic [RES_W-1:0] approx, trialMask, trial, nextApprox;
  logic [RES_W-1:0] resQ [NUM_CH];
  logic             ctrlWr, chanWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(0));
  assign chanWr = wrEn && (wrAddr == ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= '0;
      startFlag <= 1'b0;
      refOn     <= 1'b0;
      shEn      <= 1'b0;
      divSel    <= '0;
      chanField <= '0;
    end else begin
      if (ctrlWr) begin
        mode      <= wrData[2:0];
        startFlag <= wrData[3] & wrData[4];
        refOn     <= wrData[4];
        shEn      <= wrData[5];
        divSel    <= wrData[7:6];
      end else if (stb.clearStart) begin
        startFlag <= 1'b0;
      end
      if (chanWr)
        chanField <= (wrData[CH_W-1:0] > CH_W'(NUM_CH - 1)) ? CH_W'(NUM_CH - 1)
                                                            : wrData[CH_W-1:0];
    end
  end

  assign trialMask  = RES_W'(1) << stb.bitIdx;
  assign trial      = approx | trialMask;
  assign nextApprox = cmpHigh ? trial : approx;
  assign dacCode    = stb.sarActive ? trial : '0;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearApprox)          approx <= '0;
    else if (stb.tick && stb.sarActive)    approx <= nextApprox;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rstN)
        resQ[g] <= '0;
      else if (stb.writeResult && stb.chan == CH_W'(g))
        resQ[g] <= nextApprox;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(0))      rdData = {divSel, shEn, refOn, startFlag, mode};
    else if (rdAddr == ADDR_W'(1)) rdData = RES_W'(chanField);
    else
      for (int i = 0; i < NUM_CH; i++)
        if (rdAddr == ADDR_W'(i + 2)) rdData = resQ[i];
  end
endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int LEN_PLAIN = 49,
  parameter int LEN_SH    = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [RES_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [RES_W-1:0]  rdData,
  input  logic              cmpHigh,
  output logic [RES_W-1:0]  dacCode,
  output logic [CH_W-1:0]   chanSel,
  output logic              busy,
  output logic              done
);
  strobe_t         stb;
  logic            tick, startFlag, shEn, refOn;
  logic [2:0]      mode;
  logic [CH_W-1:0] chanField;
  logic [1:0]      divSel;

  sar_prescaler u_pre (
    .clk(clk), .rstN(rstN), .run(busy), .divSel(divSel), .tick(tick)
  );

  sar_ctrl #(.NUM_CH(NUM_CH), .LEN_PLAIN(LEN_PLAIN), .LEN_SH(LEN_SH)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .startFlag(startFlag), .mode(mode),
    .chanField(chanField), .shEn(shEn), .busy(busy), .done(done), .stb(stb)
  );

  sar_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .cmpHigh(cmpHigh), .stb(stb), .rdData(rdData),
    .dacCode(dacCode), .startFlag(startFlag), .mode(mode), .chanField(chanField),
    .shEn(shEn), .divSel(divSel), .refOn(refOn)
  );

  assign chanSel = stb.chan;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int NUM_CH = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       refOn,
  input logic [7:0] dacCode,
  input logic [2:0] chanSel
);
  // R12: the done strobe lasts one clock
  p_done_one_clock_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: done only follows an active run
  p_done_in_run_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R13: no trial code while idle
  p_dac_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> dacCode == 8'd0);

  // R13: channel index within range
  p_chan_bound_r13: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> chanSel < 3'(NUM_CH));

  // R13: channel held for a whole conversion
  p_chan_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !done) |-> $stable(chanSel));

  // R6: a run never begins without the reference connected
  p_ref_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> refOn);
endmodule

bind adc_sar_sequencer sar_seq_checker #(.NUM_CH(NUM_CH)) chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .refOn(refOn),
  .dacCode(dacCode), .chanSel(chanSel)
);

// File: tb/tb_adc_sar_sequencer.sv
module tb_adc_sar_sequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData, dacCode;
  logic [2:0] chanSel;
  logic       busy, done, cmpHigh;
  logic [7:0] anaVal [6];

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int logN = 0;
  int logChan [1024];
  int logCyc [1024];
  logic [2:0] prevChan = '0;
  int startCyc = 0;

  always #10 clk = ~clk;

  assign cmpHigh = (anaVal[chanSel] >= dacCode);

  adc_sar_sequencer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cmpHigh(cmpHigh), .dacCode(dacCode),
    .chanSel(chanSel), .busy(busy), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (done) begin
      if (logN < 1024) begin
        logChan[logN] = int'(prevChan);
        logCyc[logN]  = cyc;
      end
      logN = logN + 1;
    end
    prevChan = chanSel;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrlB(input int md, input bit st, input bit rf,
                                       input bit sh, input int dv);
    return {2'(dv), sh, rf, st, 3'(md)};
  endfunction

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    startCyc = cyc;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic waitIdle(input int limit);
    int n = 0;
    repeat (2) @(negedge clk);
    while (busy && n < limit) begin @(negedge clk); n++; end
    @(negedge clk);
    if (n >= limit) check(1'b0, "timeout idle", n, limit);
  endtask

  task automatic waitDones(input int target, input int limit);
    int n = 0;
    while (logN < target && n < limit) begin @(negedge clk); n++; end
    if (n >= limit) check(1'b0, "timeout done", logN, target);
  endtask

  function automatic int divOf(input int dv);
    return (dv == 0) ? 1 : (dv == 1) ? 2 : 4;
  endfunction

  task automatic runOnce(input int ch, input logic [7:0] v, input bit sh, input int dv);
    int base;
    int len;
    logic [7:0] r;
    anaVal[ch] = v;
    len = sh ? 28 : 49;
    wrReg(3'd1, 8'(ch));
    base = logN;
    wrReg(3'd0, ctrlB(0, 1, 1, sh, dv));
    waitIdle(400);
    check(logN == base + 1, "R7 one done", logN - base, 1);
    check(logCyc[base] - startCyc == 2 + len * divOf(dv), "R5 latency",
          logCyc[base] - startCyc, 2 + len * divOf(dv));
    check(logChan[base] == ch, "R7 channel", logChan[base], ch);
    rdReg(3'(ch + 2), r);
    check(r == v, "R3 result", r, v);
    rdReg(3'd0, r);
    check(r[3] == 1'b0, "R7 start cleared", r[3], 0);
  endtask

  task automatic checkSeq(input int base, input int n, input int exp [16], input string tag);
    for (int i = 0; i < n; i++)
      check(logChan[base + i] == exp[i], tag, logChan[base + i], exp[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int base;
    int seq [16];
    for (int i = 0; i < 6; i++) anaVal[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(dacCode == 0, "R1 dac", dacCode, 0);
    rdReg(3'd0, r); check(r == 0, "R1 ctrl", r, 0);
    rdReg(3'd1, r); check(r == 0, "R1 chan", r, 0);
    for (int i = 0; i < 6; i++) begin
      rdReg(3'(i + 2), r); check(r == 0, "R1 result", r, 0);
    end

    // R2 register map and channel saturation
    wrReg(3'd1, 8'd7);
    rdReg(3'd1, r); check(r == 5, "R2 chan saturate", r, 5);
    wrReg(3'd0, ctrlB(2, 0, 1, 1, 2));
    rdReg(3'd0, r); check(r == 8'hB2, "R2 ctrl fields", r, 8'hB2);

    // R6 start without reference is ignored
    base = logN;
    wrReg(3'd0, ctrlB(0, 1, 0, 1, 0));
    rdReg(3'd0, r); check(r[3] == 0, "R6 start cleared", r[3], 0);
    repeat (60) @(negedge clk);
    check(busy == 0, "R6 no busy", busy, 0);
    check(logN == base, "R6 no done", logN - base, 0);

    // R3/R4/R5/R7 one-shot over prescale, sample-and-hold and channel
    for (int dv = 0; dv < 3; dv++)
      for (int sh = 0; sh < 2; sh++)
        for (int ch = 0; ch < 6; ch++)
          runOnce(ch, 8'((ch * 41 + dv * 77 + sh * 13 + 5) & 255), 1'(sh), dv);
    // R4 code 3 behaves as divide by 4
    runOnce(2, 8'd200, 1'b1, 3);

    // R3 every code value
    for (int v = 0; v < 256; v++) runOnce(v % 6, 8'(v), 1'b1, 0);

    // R8 repeat mode with divide by 2, sample-and-hold off
    anaVal[3] = 8'd99;
    wrReg(3'd1, 8'd3);
    base = logN;
    wrReg(3'd0, ctrlB(1, 1, 1, 0, 1));
    waitDones(base + 3, 2000);
    wrReg(3'd0, ctrlB(1, 0, 1, 0, 1));
    waitIdle(400);
    check(logN == base + 4, "R8 one more after clear", logN - base, 4);
    check(logCyc[base + 1] - logCyc[base] == 98, "R5 repeat spacing",
          logCyc[base + 1] - logCyc[base], 98);
    check(logCyc[base + 2] - logCyc[base + 1] == 98, "R5 repeat spacing",
          logCyc[base + 2] - logCyc[base + 1], 98);
    for (int i = 0; i < 4; i++) seq[i] = 3;
    checkSeq(base, 4, seq, "R8 channel");
    rdReg(3'd5, r); check(r == 99, "R8 result", r, 99);

    // R9 single sweep to AN4
    for (int i = 0; i < 6; i++) anaVal[i] = 8'(250 - i * 45);
    wrReg(3'd1, 8'd4);
    base = logN;
    wrReg(3'd0, ctrlB(2, 1, 1, 1, 0));
    waitIdle(1000);
    check(logN == base + 5, "R9 count", logN - base, 5);
    for (int i = 0; i < 5; i++) seq[i] = i;
    checkSeq(base, 5, seq, "R9 order");
    for (int i = 0; i < 5; i++) begin
      rdReg(3'(i + 2), r); check(r == anaVal[i], "R9 result", r, anaVal[i]);
    end
    rdReg(3'd0, r); check(r[3] == 0, "R9 start cleared", r[3], 0);

    // R10 loop sweep to AN2, divide by 4
    for (int i = 0; i < 6; i++) anaVal[i] = 8'(i * 17 + 3);
    wrReg(3'd1, 8'd2);
    base = logN;
    wrReg(3'd0, ctrlB(3, 1, 1, 1, 2));
    waitDones(base + 7, 8000);
    wrReg(3'd0, ctrlB(3, 0, 1, 1, 2));
    waitIdle(1000);
    check(logN == base + 8, "R10 count", logN - base, 8);
    check(logCyc[base + 1] - logCyc[base] == 112, "R5 spacing div4",
          logCyc[base + 1] - logCyc[base], 112);
    seq[0] = 0; seq[1] = 1; seq[2] = 2; seq[3] = 0;
    seq[4] = 1; seq[5] = 2; seq[6] = 0; seq[7] = 1;
    checkSeq(base, 8, seq, "R10 order");
    for (int i = 0; i < 3; i++) begin
      rdReg(3'(i + 2), r); check(r == anaVal[i], "R10 result", r, anaVal[i]);
    end

    // R11 loop sweep with AN0 between, last AN3
    wrReg(3'd1, 8'd3);
    base = logN;
    wrReg(3'd0, ctrlB(4, 1, 1, 1, 0));
    waitDones(base + 8, 4000);
    wrReg(3'd0, ctrlB(4, 0, 1, 1, 0));
    waitIdle(1000);
    check(logN == base + 9, "R11 count", logN - base, 9);
    seq[0] = 0; seq[1] = 1; seq[2] = 0; seq[3] = 2; seq[4] = 0;
    seq[5] = 3; seq[6] = 0; seq[7] = 1; seq[8] = 0;
    checkSeq(base, 9, seq, "R11 order");
    rdReg(3'd5, r); check(r == anaVal[3], "R11 result", r, anaVal[3]);

    // R12/R13 idle outputs after all runs
    check(done == 0, "R12 done low", done, 0);
    check(dacCode == 0, "R13 dac idle", dacCode, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule